// File: doc/BRIEF.md
# Bit-addressable internal data memory and special-register store

This block holds the internal scratch RAM and the special-function registers of a small 8-bit microcontroller core. The core's decoder presents one request per cycle on a request channel. A request is a byte read or a byte write, addressed directly, indirectly or as a working register. It can also be a single-bit read, set or clear, addressed by an 8-bit bit number. The block answers each request on a response channel one cycle later.

A bit number below 128 selects a byte in a 16-byte bit area of RAM. A bit number of 128 or more selects a special register whose address is a multiple of 8. Working registers are placed through a bank selected by two bits of the status register. Registers that implement only some of their bits store the implemented bits only. Two port registers return either their output latch or the external pins, depending on whether the access is a read-modify-write.

Writes to the serial buffer address and to the three interrupt-configuration addresses give single-cycle strobes. Other blocks consume these strobes. An access outside the implemented space is refused and flagged.

The request channel carries a valid bit but no ready bit. The block accepts a request in every cycle, so the requester never stalls. The response channel has no ready bit either. The consumer must take each response in the cycle it is valid, because the response is replaced on the next cycle.

Top module: `bitaddr_data_mem`

## Requirements
- R1: After reset, every RAM byte reads 0x00, the port latches at 0x80 and 0x90 read 0xFF, 0x81 reads 0x07, every other implemented register reads 0x00, `bank` is 0 and `rsp_valid` is low.
- R2: The operation codes on `req_op` are 1 direct read, 2 direct write, 3 indirect read, 4 indirect write, 5 working-register read, 6 working-register write, 7 bit read, 8 bit set and 9 bit clear. Any other code does nothing.
  - A direct address below 0x80 reaches RAM. A direct address of 0x80 or above reaches the special registers.
  - `rsp_valid` and `rsp_data` appear one cycle after the request.
  - A write is visible to a request made in the next cycle.
- R3: A bit number below 128 selects the byte at 0x20 plus the bit number divided by 8. The bit position within that byte is the bit number modulo 8.
  - A set or a clear changes that one bit and leaves the other seven bits unchanged.
  - `rsp_bit` returns the value the bit had before the operation.
- R4: A bit number of 128 or more selects the register at the bit number with its low three bits cleared. The bit position is the low three bits.
- R5: Working register n, taken from `req_addr[2:0]`, is the RAM byte at bank×8+n. The bank is bits 4:3 of the status register at 0xD0, and it also drives `bank`.
- R6: Some registers implement only part of their bits: 0xA8 (mask 0x9F), 0xB7 (mask 0x1F) and 0xB8 (mask 0x1F).
  - A write to one of them stores only the implemented bits.
  - A read returns the implemented bits, with UNDEF_FILL (default 0x00) in the other positions.
- R7: A read of 0x80 or 0x90, byte or bit, returns the output latch when `req_rmw` is high. Otherwise it returns the pins: `port_pins[7:0]` for 0x80 and `port_pins[15:8]` for 0x90.
  - A bit set or clear always modifies the latch.
- R8: A direct write to 0x99 raises `tx_start` for exactly one cycle, in the cycle after the write, with `tx_data` equal to the written value. A read of 0x99 returns `rx_data`.
- R9: A write to 0xA8, 0xB7 or 0xB8, by byte or by bit, raises `int_hold` for exactly one cycle in the cycle after the write. A write elsewhere leaves it low.
- R10: An access to an unlisted register raises `rsp_err` and returns UNDEF_FILL. An access to RAM at or above IRAM_SIZE does the same.
  - The listed registers are 0x80, 0x81, 0x82, 0x83, 0x90, 0x98, 0x99, 0xA8, 0xB7, 0xB8, 0xD0, 0xE0 and 0xF0.
  - A refused write changes no state.
- R11: Indirect accesses always reach RAM, including 0x80–0xFF when IRAM_SIZE is 256, and never reach the special registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | 8 | Byte address, bit number or working-register index |
| req_wdata | input | 8 | Write data for byte writes |
| req_rmw | input | 1 | The access belongs to a read-modify-write instruction |
| port_pins | input | 16 | External pin levels of the two ports |
| rx_data | input | 8 | Received serial byte, returned on reads of 0x99 |
| rsp_valid | output | 1 | A response is present this cycle |
| rsp_data | output | 8 | Byte read, or the byte before modification |
| rsp_bit | output | 1 | Addressed bit for bit operations |
| rsp_err | output | 1 | The request addressed unimplemented space |
| tx_start | output | 1 | Pulse: start serial transmission |
| tx_data | output | 8 | Byte to transmit |
| int_hold | output | 1 | Pulse: delay interrupt servicing by one instruction |
| bank | output | 2 | Current working-register bank |

## Verification
All results except `bank` are registered. `rsp_valid`, `rsp_data`, `rsp_bit`, `rsp_err`, `tx_start` and `int_hold` therefore belong to the clock edge that samples the request, and `bank` follows the status write at that same edge.

The bench drives each request on a falling edge. It compares every output on the following falling edge, half a period after the capturing edge. Read-after-write cases issue the read in the very next cycle.

Pulse checks look again one cycle later to confirm the strobe has dropped. The reset checks read the state back through ordinary requests after a second reset pulse.

// File: rtl/bitmem_pkg.sv
package bitmem_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_RD_DIR  = 4'd1,
    OP_WR_DIR  = 4'd2,
    OP_RD_IND  = 4'd3,
    OP_WR_IND  = 4'd4,
    OP_RD_REG  = 4'd5,
    OP_WR_REG  = 4'd6,
    OP_BIT_RD  = 4'd7,
    OP_BIT_SET = 4'd8,
    OP_BIT_CLR = 4'd9
  } mem_op_e;

  localparam logic [3:0] OP_LAST = 4'd9;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_SFR  = 2'd2
  } tgt_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] mask;
    logic [7:0] rst;
    logic       is_port;
    logic       port_no;
  } sfr_desc_t;

  localparam logic [7:0] ADDR_PORTA      = 8'h80;
  localparam logic [7:0] ADDR_STACK      = 8'h81;
  localparam logic [7:0] ADDR_PTR_LO     = 8'h82;
  localparam logic [7:0] ADDR_PTR_HI     = 8'h83;
  localparam logic [7:0] ADDR_PORTB      = 8'h90;
  localparam logic [7:0] ADDR_SERCTL     = 8'h98;
  localparam logic [7:0] ADDR_SERBUF     = 8'h99;
  localparam logic [7:0] ADDR_IRQ_EN     = 8'hA8;
  localparam logic [7:0] ADDR_IRQ_PRI_HI = 8'hB7;
  localparam logic [7:0] ADDR_IRQ_PRI    = 8'hB8;
  localparam logic [7:0] ADDR_STATUS     = 8'hD0;
  localparam logic [7:0] ADDR_ACCUM      = 8'hE0;
  localparam logic [7:0] ADDR_AUX        = 8'hF0;

  localparam logic [7:0] BIT_AREA_BASE   = 8'h20;

  localparam int NSFR = 13;

  localparam sfr_desc_t SFR_TABLE [NSFR] = '{
    '{ADDR_PORTA,      8'hFF, 8'hFF, 1'b1, 1'b0},
    '{ADDR_STACK,      8'hFF, 8'h07, 1'b0, 1'b0},
    '{ADDR_PTR_LO,     8'hFF, 8'h00, 1'b0, 1'b0},
    '{ADDR_PTR_HI,     8'hFF, 8'h00, 1'b0, 1'b0},
    '{ADDR_PORTB,      8'hFF, 8'hFF, 1'b1, 1'b1},
    '{ADDR_SERCTL,     8'hFF, 8'h00, 1'b0, 1'b0},
    '{ADDR_SERBUF,     8'hFF, 8'h00, 1'b0, 1'b0},
    '{ADDR_IRQ_EN,     8'h9F, 8'h00, 1'b0, 1'b0},
    '{ADDR_IRQ_PRI_HI, 8'h1F, 8'h00, 1'b0, 1'b0},
    '{ADDR_IRQ_PRI,    8'h1F, 8'h00, 1'b0, 1'b0},
    '{ADDR_STATUS,     8'hFF, 8'h00, 1'b0, 1'b0},
    '{ADDR_ACCUM,      8'hFF, 8'h00, 1'b0, 1'b0},
    '{ADDR_AUX,        8'hFF, 8'h00, 1'b0, 1'b0}
  };

endpackage

// File: rtl/bitmem_decode.sv
module bitmem_decode
  import bitmem_pkg::*;
#(
  parameter int IRAM_SIZE = 256,
  parameter int RAM_AW    = 8,
  parameter int SW        = 4
) (
  input  mem_op_e           op,
  input  logic [7:0]        addr,
  input  logic [1:0]        bank,
  output tgt_e              tgt,
  output logic [7:0]        byte_addr,
  output logic [RAM_AW-1:0] ram_idx,
  output logic [SW-1:0]     sfr_idx,
  output logic [2:0]        bit_pos,
  output logic              err
);

  logic want_ram;
  logic want_sfr;
  logic sfr_hit;
  logic ram_ok;

  // Address formation per addressing mode
  always_comb begin
    want_ram  = 1'b0;
    want_sfr  = 1'b0;
    byte_addr = addr;
    bit_pos   = 3'd0;
    case (op)
      OP_RD_DIR, OP_WR_DIR: begin
        want_sfr = addr[7];
        want_ram = !addr[7];
      end
      OP_RD_IND, OP_WR_IND: begin
        want_ram = 1'b1;
      end
      OP_RD_REG, OP_WR_REG: begin
        byte_addr = {3'b000, bank, addr[2:0]};
        want_ram  = 1'b1;
      end
      OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR: begin
        bit_pos  = addr[2:0];
        want_sfr = addr[7];
        want_ram = !addr[7];
        byte_addr = addr[7] ? {addr[7:3], 3'b000}
                            : (BIT_AREA_BASE | {4'b0000, addr[6:3]});
      end
      default: ;
    endcase
  end

  // Register lookup against the implemented list
  always_comb begin
    sfr_hit = 1'b0;
    sfr_idx = '0;
    for (int i = 0; i < NSFR; i++) begin
      if (SFR_TABLE[i].addr == byte_addr) begin
        sfr_hit = 1'b1;
        sfr_idx = SW'(i);
      end
    end
  end

  assign ram_ok  = 9'(byte_addr) < 9'(IRAM_SIZE);
  assign ram_idx = byte_addr[RAM_AW-1:0];

  always_comb begin
    if (want_ram)      tgt = TGT_RAM;
    else if (want_sfr) tgt = TGT_SFR;
    else               tgt = TGT_NONE;
    err = (want_ram && !ram_ok) || (want_sfr && !sfr_hit);
  end

endmodule

// File: rtl/bitmem_iram.sv
module bitmem_iram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/bitmem_sfr_file.sv
module bitmem_sfr_file
  import bitmem_pkg::*;
#(
  parameter int         SW         = 4,
  parameter logic [7:0] UNDEF_FILL = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] idx,
  input  logic [7:0]    wdata,
  input  logic          rmw,
  input  logic [15:0]   port_pins,
  input  logic [7:0]    rx_data,
  output logic [7:0]    rd_view,
  output logic [7:0]    rd_latch,
  output logic [7:0]    status_q
);

  logic [NSFR*8-1:0] flat;

  for (genvar g = 0; g < NSFR; g++) begin : g_reg
    localparam sfr_desc_t D = SFR_TABLE[g];
    logic [7:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= D.rst;
      else if (we && idx == SW'(g) && D.addr != ADDR_SERBUF)
        q <= wdata & D.mask;
    end

    assign flat[g*8 +: 8] = q;

    // R6
    unimpl_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~D.mask) == 8'h00);
  end

  always_comb begin
    rd_view  = UNDEF_FILL;
    rd_latch = 8'h00;
    status_q = 8'h00;
    for (int i = 0; i < NSFR; i++) begin
      if (idx == SW'(i)) begin
        rd_latch = flat[i*8 +: 8];
        if (SFR_TABLE[i].is_port && !rmw)
          rd_view = port_pins[int'(SFR_TABLE[i].port_no)*8 +: 8];
        else if (SFR_TABLE[i].addr == ADDR_SERBUF)
          rd_view = rx_data;
        else
          rd_view = (flat[i*8 +: 8] & SFR_TABLE[i].mask) |
                    (~SFR_TABLE[i].mask & UNDEF_FILL);
      end
      if (SFR_TABLE[i].addr == ADDR_STATUS)
        status_q = flat[i*8 +: 8];
    end
  end

endmodule

// File: rtl/bitaddr_data_mem.sv
module bitaddr_data_mem
  import bitmem_pkg::*;
#(
  parameter int         IRAM_SIZE  = 256,
  parameter logic [7:0] UNDEF_FILL = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [3:0]  req_op,
  input  logic [7:0]  req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        req_rmw,
  input  logic [15:0] port_pins,
  input  logic [7:0]  rx_data,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        rsp_bit,
  output logic        rsp_err,
  output logic        tx_start,
  output logic [7:0]  tx_data,
  output logic        int_hold,
  output logic [1:0]  bank
);

  localparam int RAM_AW = $clog2(IRAM_SIZE);
  localparam int SW     = $clog2(NSFR);

  mem_op_e           op;
  tgt_e              tgt;
  logic [7:0]        byte_addr;
  logic [RAM_AW-1:0] ram_idx;
  logic [SW-1:0]     sfr_idx;
  logic [2:0]        bit_pos;
  logic              err;
  logic [7:0]        ram_q;
  logic [7:0]        sfr_view;
  logic [7:0]        sfr_latch;
  logic [7:0]        status_q;
  logic              bit_modify;
  logic              is_write;
  logic [7:0]        bit_mask;
  logic [7:0]        base;
  logic [7:0]        new_byte;
  logic [7:0]        wval;
  logic [7:0]        view;
  logic              ram_we;
  logic              sfr_we;
  logic              irq_cfg_hit;

  always_comb begin
    if (!req_valid || req_op > OP_LAST) op = OP_NOP;
    else                                op = mem_op_e'(req_op);
  end

  bitmem_decode #(
    .IRAM_SIZE (IRAM_SIZE),
    .RAM_AW    (RAM_AW),
    .SW        (SW)
  ) u_decode (
    .op        (op),
    .addr      (req_addr),
    .bank      (bank),
    .tgt       (tgt),
    .byte_addr (byte_addr),
    .ram_idx   (ram_idx),
    .sfr_idx   (sfr_idx),
    .bit_pos   (bit_pos),
    .err       (err)
  );

  bitmem_iram #(
    .DEPTH (IRAM_SIZE),
    .AW    (RAM_AW)
  ) u_iram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .addr  (ram_idx),
    .wdata (wval),
    .rdata (ram_q)
  );

  bitmem_sfr_file #(
    .SW         (SW),
    .UNDEF_FILL (UNDEF_FILL)
  ) u_sfr (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (sfr_we),
    .idx       (sfr_idx),
    .wdata     (wval),
    .rmw       (req_rmw),
    .port_pins (port_pins),
    .rx_data   (rx_data),
    .rd_view   (sfr_view),
    .rd_latch  (sfr_latch),
    .status_q  (status_q)
  );

  // Single-cycle read-modify-write path for bit set and clear
  always_comb begin
    bit_modify  = (op == OP_BIT_SET) || (op == OP_BIT_CLR);
    is_write    = bit_modify || (op == OP_WR_DIR) || (op == OP_WR_IND) ||
                  (op == OP_WR_REG);
    bit_mask    = 8'h01 << bit_pos;
    base        = (tgt == TGT_RAM) ? ram_q : sfr_latch;
    new_byte    = (op == OP_BIT_SET) ? (base | bit_mask) : (base & ~bit_mask);
    wval        = bit_modify ? new_byte : req_wdata;
    view        = (tgt == TGT_RAM) ? ram_q : sfr_view;
    ram_we      = is_write && !err && (tgt == TGT_RAM);
    sfr_we      = is_write && !err && (tgt == TGT_SFR);
    irq_cfg_hit = (byte_addr == ADDR_IRQ_EN) || (byte_addr == ADDR_IRQ_PRI) ||
                  (byte_addr == ADDR_IRQ_PRI_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
      rsp_bit   <= 1'b0;
      rsp_err   <= 1'b0;
      tx_start  <= 1'b0;
      tx_data   <= 8'h00;
      int_hold  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err;
      rsp_data  <= err ? UNDEF_FILL : view;
      rsp_bit   <= err ? 1'b0 : view[bit_pos];
      tx_start  <= sfr_we && (byte_addr == ADDR_SERBUF);
      if (sfr_we && byte_addr == ADDR_SERBUF) tx_data <= req_wdata;
      int_hold  <= sfr_we && irq_cfg_hit;
    end
  end

  assign bank = status_q[4:3];

  // R8
  tx_start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(req_valid && req_op == 4'd2 && req_addr == ADDR_SERBUF));

  // R9
  int_hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_hold |-> $past(req_valid && (req_op == 4'd2 || req_op == 4'd8 || req_op == 4'd9)));

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_data == UNDEF_FILL && !tx_start && !int_hold && rsp_valid));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> $stable(bank));

endmodule

// File: tb/test_bitaddr_data_mem.sv
module test_bitaddr_data_mem;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] RD  = 4'd1, WR  = 4'd2, RI  = 4'd3, WI = 4'd4;
  localparam logic [3:0] RR  = 4'd5, WRG = 4'd6, BR  = 4'd7, BS = 4'd8, BC = 4'd9;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] addr;
    logic [7:0] wd;
    logic       rmw;
    logic       cd;
    logic [7:0] ed;
    logic       cb;
    logic       eb;
    logic       ee;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VECS [NV] = '{
    '{RD,  8'h81, 8'h00, 1'b0, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
    '{RD,  8'h80, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
    '{RD,  8'h80, 8'h00, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{RI,  8'h45, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
    '{WR,  8'h30, 8'hA5, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{RD,  8'h30, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{WR,  8'hE0, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{RD,  8'hE0, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{BS,  8'h0B, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{RD,  8'h21, 8'h00, 1'b0, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    '{WR,  8'h2F, 8'h7E, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{BC,  8'h7A, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd3},  // R3
    '{RD,  8'h2F, 8'h00, 1'b0, 1'b1, 8'h7A, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    '{BR,  8'h79, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd3},  // R3
    '{BS,  8'hF7, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{RD,  8'hF0, 8'h00, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{BS,  8'hD3, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{WRG, 8'h02, 8'h99, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{RI,  8'h0A, 8'h00, 1'b0, 1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{RR,  8'h02, 8'h00, 1'b0, 1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{WR,  8'hD0, 8'h18, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{WRG, 8'h07, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{RD,  8'h1F, 8'h00, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{WR,  8'hD0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{RR,  8'h07, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{WR,  8'hB8, 8'hE5, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{RD,  8'hB8, 8'h00, 1'b0, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{BS,  8'hAE, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{RD,  8'hA8, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{BC,  8'h90, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{RD,  8'h90, 8'h00, 1'b1, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{RD,  8'h90, 8'h00, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{BR,  8'h92, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd7},  // R7
    '{BR,  8'h92, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd7},  // R7
    '{RD,  8'h99, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{RD,  8'h88, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{WR,  8'h88, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{BS,  8'h8A, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{RD,  8'h80, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{WI,  8'h90, 8'h42, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{RI,  8'h90, 8'h00, 1'b0, 1'b1, 8'h42, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{RD,  8'h90, 8'h00, 1'b1, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{WI,  8'hD0, 8'h18, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{RD,  8'hD0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{RR,  8'h07, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [7:0]  req_addr;
  logic [7:0]  req_wdata;
  logic        req_rmw;
  logic [15:0] port_pins;
  logic [7:0]  rx_data;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rsp_bit;
  logic        rsp_err;
  logic        tx_start;
  logic [7:0]  tx_data;
  logic        int_hold;
  logic [1:0]  bank;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitaddr_data_mem i_bitaddr_data_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_rmw   (req_rmw),
    .port_pins (port_pins),
    .rx_data   (rx_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_bit   (rsp_bit),
    .rsp_err   (rsp_err),
    .tx_start  (tx_start),
    .tx_data   (tx_data),
    .int_hold  (int_hold),
    .bank      (bank)
  );

  task automatic chk(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual=%02h expected=%02h", rq, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with results settled
  task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] wd, input logic rmw);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = a;
    req_wdata = wd;
    req_rmw   = rmw;
    @(negedge clk);
    req_valid = 1'b0;
    req_op    = 4'd0;
    req_rmw   = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 4'd0; req_addr = 8'h00;
    req_wdata = 8'h00; req_rmw = 1'b0; port_pins = 16'hC35A; rx_data = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    chk(1, "bank after reset", {6'b0, bank}, 8'h00);
    chk(1, "rsp_valid idle", {7'b0, rsp_valid}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      issue(VECS[v].op, VECS[v].addr, VECS[v].wd, VECS[v].rmw);
      chk(int'(VECS[v].rq), $sformatf("vec %0d rsp_valid", v), {7'b0, rsp_valid}, 8'h01);
      chk(int'(VECS[v].rq), $sformatf("vec %0d rsp_err", v), {7'b0, rsp_err}, {7'b0, VECS[v].ee});
      if (VECS[v].cd)
        chk(int'(VECS[v].rq), $sformatf("vec %0d rsp_data", v), rsp_data, VECS[v].ed);
      if (VECS[v].cb)
        chk(int'(VECS[v].rq), $sformatf("vec %0d rsp_bit", v), {7'b0, rsp_bit}, {7'b0, VECS[v].eb});
    end

    // R8 transmit strobe is a single pulse carrying the written byte
    issue(WR, 8'h99, 8'h6B, 1'b0);
    chk(8, "tx_start pulse", {7'b0, tx_start}, 8'h01);
    chk(8, "tx_data", tx_data, 8'h6B);
    @(negedge clk);
    chk(8, "tx_start dropped", {7'b0, tx_start}, 8'h00);

    // R9 interrupt hold from byte and bit writes, not from others
    issue(WR, 8'hB7, 8'h03, 1'b0);
    chk(9, "int_hold after byte write", {7'b0, int_hold}, 8'h01);
    @(negedge clk);
    chk(9, "int_hold dropped", {7'b0, int_hold}, 8'h00);
    issue(BS, 8'hAF, 8'h00, 1'b0);
    chk(9, "int_hold after bit set", {7'b0, int_hold}, 8'h01);
    issue(WR, 8'hE0, 8'h01, 1'b0);
    chk(9, "int_hold quiet on other write", {7'b0, int_hold}, 8'h00);
    chk(8, "tx_start quiet on other write", {7'b0, tx_start}, 8'h00);

    // R5 bank output follows status bits 4:3
    issue(WR, 8'hD0, 8'h10, 1'b0);
    chk(5, "bank port", {6'b0, bank}, 8'h02);
    issue(WRG, 8'h01, 8'h77, 1'b0);
    issue(RD, 8'h11, 8'h00, 1'b0);
    chk(5, "bank 2 register 1", rsp_data, 8'h77);

    // R1 second reset restores everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, "bank after re-reset", {6'b0, bank}, 8'h00);
    issue(RD, 8'h30, 8'h00, 1'b0);
    chk(1, "RAM cleared", rsp_data, 8'h00);
    issue(RD, 8'hB8, 8'h00, 1'b0);
    chk(1, "register reset value", rsp_data, 8'h00);
    issue(RD, 8'h90, 8'h00, 1'b1);
    chk(1, "port latch reset", rsp_data, 8'hFF);
    issue(RI, 8'h90, 8'h00, 1'b0);
    chk(1, "upper RAM cleared", rsp_data, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule